// File: doc/BRIEF.md
# Chip-Enable Write-Protect Gate

This block sits in the chip-select or write-strobe path between a processor and a battery-backed RAM. While the supply is reported good, the active-low strobe passes straight through. While the supply is bad (brownout, power-up, power-down), the gated strobe is forced inactive (high), so the processor cannot write corrupt data into the RAM.

An access that is already under way when the supply drops is not cut off abruptly. The strobe may keep the RAM selected for a bounded hold window of `HOLD_CYC` clock cycles. The window ends early as soon as the processor releases the strobe. The clock drives only this hold timer. In the pass-through state the path from input to output is combinational, so the gate adds no cycle of latency.

Top module: `cewp_gate`

## Requirements
- R1: After a synchronous reset with `supply_ok` low, `ce_out_n` is high whatever `ce_in_n` does.
- R2: While `supply_ok` is high, `ce_out_n` equals `ce_in_n` in the same cycle, with no clock latency.
- R3: While `supply_ok` is low and no hold window is open, `ce_out_n` is high for both values of `ce_in_n`.
- R4: A drop is the first cycle where `supply_ok` is low after it was high at the previous rising edge. If `ce_in_n` is low in that cycle, a hold window opens and `ce_out_n` stays low in that same cycle.
- R5: A hold window keeps `ce_out_n` low for at most `HOLD_CYC` consecutive cycles, counting the drop cycle. After that, `ce_out_n` goes high even if `ce_in_n` stays low.
- R6: While a window is open, `ce_out_n` goes high in the same cycle that `ce_in_n` goes high. A later low on `ce_in_n` during the same outage does not drive `ce_out_n` low.
- R7: If `ce_in_n` is high in the drop cycle, no window opens. A later low on `ce_in_n` during that outage leaves `ce_out_n` high.
- R8: When `supply_ok` returns high, `ce_out_n` follows `ce_in_n` again from that cycle. A later drop can open a fresh window of full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the hold timer |
| rst | input | 1 | Synchronous active-high reset |
| ce_in_n | input | 1 | Active-low chip enable from the processor |
| supply_ok | input | 1 | High while the supply is valid |
| ce_out_n | output | 1 | Gated active-low chip enable to the RAM |

## Verification
The bench holds the strobe low across a drop and keeps it low past the window, to find the exact cycle the output releases. A timer that is off by one would release one cycle early or late, and a gate without a timer would never release. It then releases and re-asserts the strobe inside the window. A design that reopened the window would drive the RAM again during the outage. It also drops the supply with the strobe already high and then lowers the strobe, and it restores the supply, to catch a window that opens without a drop, or that is not cleared by recovery and so comes back short.

// File: rtl/cewp_pkg.sv
package cewp_pkg;
  typedef enum logic [1:0] {
    GM_PASS  = 2'd0,
    GM_HOLD  = 2'd1,
    GM_BLOCK = 2'd2
  } gate_mode_e;
endpackage

// File: rtl/cewp_drop_detect.sv
module cewp_drop_detect (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  output logic drop_now
);
  logic supply_q;

  always_ff @(posedge clk) begin
    if (rst) supply_q <= 1'b0;
    else     supply_q <= supply_ok;
  end

  assign drop_now = supply_q & ~supply_ok;

  // R4
  drop_follows_good_chk: assert property (@(posedge clk) disable iff (rst)
    drop_now |-> $past(supply_ok));
endmodule

// File: rtl/cewp_hold_timer.sv
module cewp_hold_timer #(
  parameter int HOLD_CYC = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic ce_in_n,
  input  logic drop_now,
  output logic hold_q
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW:0] LIMIT = (CW+1)'(HOLD_CYC);

  logic [CW-1:0] cnt_q;
  logic          start;

  assign start = drop_now & ~ce_in_n;

  always_ff @(posedge clk) begin
    if (rst || supply_ok) begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      cnt_q  <= CW'(1);
      hold_q <= (HOLD_CYC > 1);
    end else if (hold_q && !ce_in_n) begin
      cnt_q  <= cnt_q + 1'b1;
      hold_q <= (({1'b0, cnt_q} + 1'b1) < LIMIT);
    end else begin
      hold_q <= 1'b0;
      cnt_q  <= '0;
    end
  end

  // R6
  hold_needs_low_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    hold_q |-> $past(!ce_in_n && !supply_ok));
endmodule

// File: rtl/cewp_mode_sel.sv
module cewp_mode_sel
  import cewp_pkg::*;
(
  input  logic       supply_ok,
  input  logic       drop_now,
  input  logic       hold_q,
  input  logic       ce_in_n,
  output gate_mode_e mode
);
  always_comb begin
    if (supply_ok)                          mode = GM_PASS;
    else if ((drop_now | hold_q) && !ce_in_n) mode = GM_HOLD;
    else                                    mode = GM_BLOCK;
  end
endmodule

// File: rtl/cewp_gate.sv
module cewp_gate
  import cewp_pkg::*;
#(
  parameter int HOLD_CYC = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic ce_in_n,
  input  logic supply_ok,
  output logic ce_out_n
);
  localparam int LW = $clog2(HOLD_CYC + 2) + 1;

  logic       drop_now;
  logic       hold_q;
  gate_mode_e mode;

  cewp_drop_detect u_drop (
    .clk      (clk),
    .rst      (rst),
    .supply_ok(supply_ok),
    .drop_now (drop_now)
  );

  cewp_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .supply_ok(supply_ok),
    .ce_in_n  (ce_in_n),
    .drop_now (drop_now),
    .hold_q   (hold_q)
  );

  cewp_mode_sel u_mode (
    .supply_ok(supply_ok),
    .drop_now (drop_now),
    .hold_q   (hold_q),
    .ce_in_n  (ce_in_n),
    .mode     (mode)
  );

  assign ce_out_n = (mode == GM_BLOCK) ? 1'b1 : ce_in_n;

  // Checker: consecutive low-output cycles during an outage
  logic [LW-1:0] low_run_q;
  always_ff @(posedge clk) begin
    if (rst || supply_ok || ce_out_n) low_run_q <= '0;
    else if (low_run_q != {LW{1'b1}}) low_run_q <= low_run_q + 1'b1;
  end

  // R5
  window_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (!supply_ok && !ce_out_n) |-> (low_run_q < LW'(HOLD_CYC)));

  // R6
  no_reopen_chk: assert property (@(posedge clk) disable iff (rst)
    (!supply_ok && $past(!supply_ok) && $past(ce_out_n)) |-> ce_out_n);

  // R4
  drop_keeps_access_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(supply_ok) && !ce_in_n) |-> !ce_out_n);

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    supply_ok |-> (ce_out_n == ce_in_n));

  // R3
  idle_strobe_high_chk: assert property (@(posedge clk) disable iff (rst)
    ce_in_n |-> ce_out_n);
endmodule

// File: tb/cewp_gate_test.sv
module cewp_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_in_n = 1'b1;
  logic supply_ok = 1'b0;
  logic ce_out_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  int prev_sup = 0;
  int win_left = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cewp_gate #(.HOLD_CYC(HOLD)) uut (
    .clk(clk), .rst(rst), .ce_in_n(ce_in_n),
    .supply_ok(supply_ok), .ce_out_n(ce_out_n)
  );

  function automatic logic model_out();
    if (supply_ok) return ce_in_n;
    if (ce_in_n) return 1'b1;
    if (!rst && prev_sup == 1) return 1'b0;
    if (win_left > 0) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      prev_sup = 0;
      win_left = 0;
    end else begin
      if (supply_ok) win_left = 0;
      else if (!ce_in_n && prev_sup == 1) win_left = HOLD - 1;
      else if (!ce_in_n && win_left > 0) win_left = win_left - 1;
      else win_left = 0;
      prev_sup = supply_ok ? 1 : 0;
    end
  end

  task automatic step(input logic ce, input logic sup, input string tag);
    @(negedge clk);
    ce_in_n = ce;
    supply_ok = sup;
    #1;
    checks++;
    if (ce_out_n !== model_out()) begin
      errors++;
      $display("FAIL %s t=%0t ce_out_n actual=%b expected=%b", tag, $time, ce_out_n, model_out());
    end
  endtask

  task automatic expect_val(input logic exp, input string tag);
    checks++;
    if (ce_out_n !== exp) begin
      errors++;
      $display("FAIL %s t=%0t ce_out_n actual=%b expected=%b", tag, $time, ce_out_n, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset with supply bad
    step(1'b0, 1'b0, "R1");
    step(1'b0, 1'b0, "R1");
    @(negedge clk); rst = 1'b0; #1;
    expect_val(1'b1, "R1");
    step(1'b0, 1'b0, "R1");
    step(1'b1, 1'b0, "R3");
    // R2 pass-through patterns
    for (int i = 0; i < 8; i++) step(logic'(i % 3 == 0), 1'b1, "R2");
    step(1'b0, 1'b1, "R2"); expect_val(1'b0, "R2");
    // R4/R5 drop with strobe held beyond the window
    step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b0, "R4"); expect_val(1'b0, "R4");
    for (int i = 1; i < HOLD; i++) begin
      step(1'b0, 1'b0, "R5"); expect_val(1'b0, "R5");
    end
    step(1'b0, 1'b0, "R5"); expect_val(1'b1, "R5");
    step(1'b0, 1'b0, "R5");
    // R8 recovery follows at once
    step(1'b0, 1'b1, "R8"); expect_val(1'b0, "R8");
    step(1'b1, 1'b1, "R8");
    step(1'b0, 1'b1, "R8");
    // R6 early release, then re-assert during the outage
    step(1'b0, 1'b0, "R6"); expect_val(1'b0, "R6");
    step(1'b0, 1'b0, "R6");
    step(1'b1, 1'b0, "R6"); expect_val(1'b1, "R6");
    step(1'b0, 1'b0, "R6"); expect_val(1'b1, "R6");
    step(1'b0, 1'b0, "R6");
    // R8 fresh full window after recovery
    step(1'b0, 1'b1, "R8");
    for (int i = 0; i < HOLD; i++) begin
      step(1'b0, 1'b0, "R8"); expect_val(1'b0, "R8");
    end
    step(1'b0, 1'b0, "R8"); expect_val(1'b1, "R8");
    // R7 drop with strobe idle
    step(1'b1, 1'b1, "R7");
    step(1'b1, 1'b0, "R7");
    step(1'b0, 1'b0, "R7"); expect_val(1'b1, "R7");
    for (int i = 0; i < 4; i++) step(logic'(i[0]), 1'b0, "R3");
    // R2 random-ish mix with occasional drops
    for (int i = 0; i < 60; i++) step(logic'((i * 7) % 5 < 2), logic'((i % 11) < 7), "R2");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule